// File: doc/BRIEF.md
# Flash Geometry Query Engine

This block is a bus master for a parallel NOR flash that supports the common flash query table. After a `start` pulse it reads the self-description table one byte at a time. For each byte it enters query mode, performs one read, and then returns the device to normal array reads. It first checks the three signature bytes. It then records the command-set code, converts the size and write-buffer exponents into byte counts, and walks the erase-region descriptors. Each descriptor becomes an entry in a small region table. An entry holds the block size, the block count, and a running start and end address.

The control is a state machine with six states. It leaves `S_IDLE` on `start` for `S_CMD`, which writes the query command. `S_CMD` hands over to `S_READ`, which fetches the table byte. `S_READ` hands over to `S_EXIT`, which writes the exit command. `S_EXIT` always goes to `S_STEP`, where the byte is consumed. `S_STEP` goes back to `S_CMD` for the next byte, or to `S_DONE` on a signature mismatch or after the last needed byte. `S_DONE` returns to `S_IDLE` after one cycle.

A single bus access is run by a sub-machine in four phases:
- `C_IDLE` accepts the request and leads to `C_SETUP`.
- `C_SETUP` holds address and data with the strobe low.
- `C_STROBE` raises the strobe.
- `C_HOLD` drops the strobe and keeps address and data.
- The sub-machine then returns to `C_IDLE`.

Each of the three timed phases lasts `wait_cycles`+1 clock cycles.

Top module: `cfi_geom_probe`

## Requirements
- R1: Each table byte costs exactly three accesses in order. The first writes 0x98 to word address 0x55. The second reads the byte offset. The third writes 0xFF to address 0x55. No read occurs outside query mode, and no two reads occur without an exit write between them.
- R2: Each access keeps the address (and the write data) stable for W+1 cycles before its strobe, strobes for W+1 cycles, and holds for W+1 cycles afterwards, where W is `wait_cycles`. Read and write strobes are never high together.
- R3: Offsets 0x10, 0x11 and 0x12 must read 0x51, 0x52 and 0x59. The first mismatch ends the run with `query_fail`=1 and `geom_valid`=0. The bytes after the mismatching one are not read. Every geometry output stays zero.
- R4: `cmdset_id` is the byte at offset 0x13.
- R5: `dev_size` is 2 to the power of the byte at offset 0x27, and `wbuf_size` is 2 to the power of the byte at offset 0x2A. Either one reads 0 when its exponent is 32 or more.
- R6: `region_count` is the byte at offset 0x2C, limited to 4. Only that many descriptors are read, region i from offsets 0x2D+4i to 0x30+4i. A successful run therefore reads 7+4·`region_count` bytes.
- R7: Descriptors are assembled little-endian, with the lowest offset in bits 7:0. The block size is 256 times bits 31:16, and the block count is bits 15:0 plus one.
- R8: Region 0 starts at 0. Each later region starts where the previous one ends. Each region's end is its start plus block size times block count, kept to 44 bits. Entries past `region_count` are zero.
- R9: `done` is high for exactly one cycle, and `geom_valid` or `query_fail` rises in that same cycle. Both flags and all results hold until the next accepted `start`, which clears them.
- R10: A `start` while a query is running is ignored. The run is not restarted and reads no extra bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a query (accepted only when idle) |
| wait_cycles | input | 4 | Extra cycles per access phase |
| done | output | 1 | One-cycle completion pulse |
| geom_valid | output | 1 | Signature matched, geometry valid |
| query_fail | output | 1 | Signature mismatch |
| cmdset_id | output | 8 | Primary command-set code |
| dev_size | output | 32 | Device size in bytes |
| wbuf_size | output | 32 | Write-buffer size in bytes |
| region_count | output | 3 | Number of recorded erase regions |
| rgn_blk_size | output | 96 | Block size per region, 24 bits each, region 0 lowest |
| rgn_blk_count | output | 68 | Block count per region, 17 bits each |
| rgn_start | output | 176 | Start address per region, 44 bits each |
| rgn_end | output | 176 | End address per region, 44 bits each |
| flash_addr | output | 8 | Flash word address |
| flash_wdata | output | 8 | Flash write data |
| flash_rdata | input | 8 | Flash read data |
| flash_wr | output | 1 | Write strobe, active high |
| flash_rd | output | 1 | Read strobe, active high |

## Verification
A wrong offset, or a slip in the byte or region counters, appears straight away at the bus. The read that follows goes to the wrong address or out of query mode, and the total read count at `done` differs from 7+4n. A corrupted assembly register or running base is not visible until the `done` pulse. There it shows in the block size, count or start/end fields of the affected region and of every region after it. Phase-counter errors show within one access, as a strobe length or setup interval different from W+1.

// File: rtl/cfi_probe_pkg.sv
package cfi_probe_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_READ, S_EXIT, S_STEP, S_DONE
    } probe_state_t;

    typedef enum logic [1:0] {
        C_IDLE, C_SETUP, C_STROBE, C_HOLD
    } cyc_state_t;

    localparam logic [7:0] CMD_QUERY = 8'h98;
    localparam logic [7:0] CMD_EXIT  = 8'hFF;
    localparam logic [7:0] QRY_WADDR = 8'h55;
    localparam logic [7:0] RGN_BASE  = 8'h2D;

    localparam logic [2:0] STEP_COUNT  = 3'd6;
    localparam logic [2:0] STEP_REGION = 3'd7;

    function automatic logic [7:0] fixed_offset(input logic [2:0] step);
        unique case (step)
            3'd0:    return 8'h10;
            3'd1:    return 8'h11;
            3'd2:    return 8'h12;
            3'd3:    return 8'h13;
            3'd4:    return 8'h27;
            3'd5:    return 8'h2A;
            default: return 8'h2C;
        endcase
    endfunction

    function automatic logic [7:0] sig_char(input logic [2:0] step);
        unique case (step)
            3'd0:    return 8'h51;
            3'd1:    return 8'h52;
            default: return 8'h59;
        endcase
    endfunction

endpackage

// File: rtl/cfi_bus_cycler.sv
module cfi_bus_cycler
    import cfi_probe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    input  logic [WAIT_W-1:0] wait_cycles,
    output logic              ack,
    output logic [7:0]        rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    output logic              bus_wr,
    output logic              bus_rd
);

    cyc_state_t        st;
    logic [WAIT_W-1:0] cnt;
    logic              rd_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= C_IDLE;
            cnt       <= '0;
            rd_op     <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            rdata     <= '0;
        end else begin
            unique case (st)
                C_IDLE: if (go) begin
                    bus_addr  <= req_addr;
                    bus_wdata <= req_wdata;
                    rd_op     <= is_read;
                    cnt       <= wait_cycles;
                    st        <= C_SETUP;
                end
                C_SETUP: if (cnt == '0) begin
                    cnt <= wait_cycles;
                    st  <= C_STROBE;
                end else cnt <= cnt - 1'b1;
                C_STROBE: if (cnt == '0) begin
                    if (rd_op) rdata <= bus_rdata;
                    cnt <= wait_cycles;
                    st  <= C_HOLD;
                end else cnt <= cnt - 1'b1;
                C_HOLD: if (cnt == '0) st <= C_IDLE;
                        else cnt <= cnt - 1'b1;
                default: st <= C_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_rd = (st == C_STROBE) &&  rd_op;
        bus_wr = (st == C_STROBE) && !rd_op;
        ack    = (st == C_HOLD) && (cnt == '0);
    end

    p_rw_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && $past(bus_rd || bus_wr)) |->
            ($stable(bus_addr) && $stable(bus_wdata)));

endmodule

// File: rtl/cfi_region_calc.sv
module cfi_region_calc #(
    parameter int BS_W = 24,
    parameter int BC_W = 17,
    parameter int RA_W = 44
) (
    input  logic [31:0]     desc,
    input  logic [RA_W-1:0] base,
    output logic [BS_W-1:0] blk_size,
    output logic [BC_W-1:0] blk_count,
    output logic [RA_W-1:0] end_addr
);
    localparam int PROD_W = BS_W + BC_W;

    logic [PROD_W-1:0] span;

    always_comb begin
        blk_size  = BS_W'({desc[31:16], 8'h00});
        blk_count = BC_W'({1'b0, desc[15:0]}) + 1'b1;
        span      = PROD_W'(blk_size) * PROD_W'(blk_count);
        end_addr  = base + RA_W'(span);
    end
endmodule

// File: rtl/cfi_geom_probe.sv
module cfi_geom_probe
    import cfi_probe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WAIT_W = 4,
    parameter int NREG   = 4,
    parameter int SIZE_W = 32,
    parameter int RA_W   = 44,
    parameter int BS_W   = 24,
    parameter int BC_W   = 17,
    localparam int CNT_W = $clog2(NREG + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [WAIT_W-1:0]      wait_cycles,
    output logic                   done,
    output logic                   geom_valid,
    output logic                   query_fail,
    output logic [7:0]             cmdset_id,
    output logic [SIZE_W-1:0]      dev_size,
    output logic [SIZE_W-1:0]      wbuf_size,
    output logic [CNT_W-1:0]       region_count,
    output logic [NREG*BS_W-1:0]   rgn_blk_size,
    output logic [NREG*BC_W-1:0]   rgn_blk_count,
    output logic [NREG*RA_W-1:0]   rgn_start,
    output logic [NREG*RA_W-1:0]   rgn_end,
    output logic [ADDR_W-1:0]      flash_addr,
    output logic [7:0]             flash_wdata,
    input  logic [7:0]             flash_rdata,
    output logic                   flash_wr,
    output logic                   flash_rd
);
    localparam int RI_W = (NREG > 1) ? $clog2(NREG) : 1;

    probe_state_t st, st_nx;
    logic [2:0]      step;
    logic [RI_W-1:0] ri;
    logic [1:0]      bi;
    logic [23:0]     desc_lo;
    logic [RA_W-1:0] base_q;
    logic            acc_busy;

    logic            go, ack;
    logic [7:0]      rbyte;
    logic [7:0]      off;
    logic [CNT_W-1:0] nr_clamp;
    logic            fail_now, end_now;

    logic [BS_W-1:0] c_bs;
    logic [BC_W-1:0] c_bc;
    logic [RA_W-1:0] c_end;

    logic [BS_W-1:0] t_bs  [NREG];
    logic [BC_W-1:0] t_bc  [NREG];
    logic [RA_W-1:0] t_st  [NREG];
    logic [RA_W-1:0] t_en  [NREG];

    cfi_bus_cycler #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) i_cycler (
        .clk(clk), .rst_n(rst_n), .go(go), .is_read(st == S_READ),
        .req_addr(st == S_READ ? ADDR_W'(off) : ADDR_W'(QRY_WADDR)),
        .req_wdata(st == S_CMD ? CMD_QUERY : CMD_EXIT),
        .wait_cycles(wait_cycles), .ack(ack), .rdata(rbyte),
        .bus_addr(flash_addr), .bus_wdata(flash_wdata), .bus_rdata(flash_rdata),
        .bus_wr(flash_wr), .bus_rd(flash_rd)
    );

    cfi_region_calc #(.BS_W(BS_W), .BC_W(BC_W), .RA_W(RA_W)) i_calc (
        .desc({rbyte, desc_lo}), .base(base_q),
        .blk_size(c_bs), .blk_count(c_bc), .end_addr(c_end)
    );

    always_comb begin
        off      = (step == STEP_REGION) ? (RGN_BASE + (8'(ri) << 2) + 8'(bi))
                                         : fixed_offset(step);
        nr_clamp = (rbyte > 8'(NREG)) ? CNT_W'(NREG) : CNT_W'(rbyte);
        fail_now = (step < 3'd3) && (rbyte != sig_char(step));
        end_now  = ((step == STEP_COUNT) && (nr_clamp == '0)) ||
                   ((step == STEP_REGION) && (bi == 2'd3) &&
                    ((CNT_W'(ri) + 1'b1) == region_count));
        go       = ((st == S_CMD) || (st == S_READ) || (st == S_EXIT)) && !acc_busy;
        done     = (st == S_DONE);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (start) st_nx = S_CMD;
            S_CMD:   if (ack) st_nx = S_READ;
            S_READ:  if (ack) st_nx = S_EXIT;
            S_EXIT:  if (ack) st_nx = S_STEP;
            S_STEP:  st_nx = (fail_now || end_now) ? S_DONE : S_CMD;
            S_DONE:  st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_busy <= 1'b0; step <= '0; ri <= '0; bi <= '0;
            desc_lo <= '0; base_q <= '0;
            geom_valid <= 1'b0; query_fail <= 1'b0; cmdset_id <= '0;
            dev_size <= '0; wbuf_size <= '0; region_count <= '0;
            for (int i = 0; i < NREG; i++) begin
                t_bs[i] <= '0; t_bc[i] <= '0; t_st[i] <= '0; t_en[i] <= '0;
            end
        end else begin
            if (go)       acc_busy <= 1'b1;
            else if (ack) acc_busy <= 1'b0;
            unique case (st)
                S_IDLE: if (start) begin
                    step <= '0; ri <= '0; bi <= '0; desc_lo <= '0; base_q <= '0;
                    geom_valid <= 1'b0; query_fail <= 1'b0; cmdset_id <= '0;
                    dev_size <= '0; wbuf_size <= '0; region_count <= '0;
                    for (int i = 0; i < NREG; i++) begin
                        t_bs[i] <= '0; t_bc[i] <= '0; t_st[i] <= '0; t_en[i] <= '0;
                    end
                end
                S_STEP: begin
                    if (fail_now) begin
                        query_fail <= 1'b1;
                        cmdset_id <= '0; dev_size <= '0; wbuf_size <= '0;
                    end else begin
                        if (end_now) geom_valid <= 1'b1;
                        unique case (step)
                            3'd3: cmdset_id <= rbyte;
                            3'd4: dev_size  <= (rbyte < 8'(SIZE_W)) ? (SIZE_W'(1) << rbyte) : '0;
                            3'd5: wbuf_size <= (rbyte < 8'(SIZE_W)) ? (SIZE_W'(1) << rbyte) : '0;
                            STEP_COUNT: region_count <= nr_clamp;
                            default: ;
                        endcase
                        if (step == STEP_REGION) begin
                            if (bi != 2'd3) begin
                                desc_lo[8*bi +: 8] <= rbyte;
                                bi <= bi + 1'b1;
                            end else begin
                                t_bs[ri] <= c_bs; t_bc[ri] <= c_bc;
                                t_st[ri] <= base_q; t_en[ri] <= c_end;
                                base_q <= c_end;
                                ri <= ri + 1'b1;
                                bi <= '0;
                            end
                        end else begin
                            step <= step + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign rgn_blk_size [g*BS_W +: BS_W] = t_bs[g];
        assign rgn_blk_count[g*BC_W +: BC_W] = t_bc[g];
        assign rgn_start    [g*RA_W +: RA_W] = t_st[g];
        assign rgn_end      [g*RA_W +: RA_W] = t_en[g];
    end

    p_cmd_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flash_wr |-> (flash_addr == ADDR_W'(QRY_WADDR)) &&
                     (flash_wdata == CMD_QUERY || flash_wdata == CMD_EXIT));

    p_flag_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(geom_valid && query_fail));

    p_count_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        region_count <= CNT_W'(NREG));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (geom_valid || query_fail));

    p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st == S_IDLE) |=> (!geom_valid && !query_fail && region_count == '0));

endmodule

// File: tb/test_cfi_geom_probe.sv
module test_cfi_geom_probe;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 4;
    localparam int RA_W = 44;

    logic clk = 0, rst_n = 0, start = 0;
    logic [3:0] wait_cycles = '0;
    logic done, geom_valid, query_fail, flash_wr, flash_rd;
    logic [7:0] cmdset_id, flash_addr, flash_wdata, flash_rdata;
    logic [31:0] dev_size, wbuf_size;
    logic [2:0] region_count;
    logic [NREG*24-1:0] rgn_blk_size;
    logic [NREG*17-1:0] rgn_blk_count;
    logic [NREG*RA_W-1:0] rgn_start, rgn_end;

    int checks = 0, errors = 0;
    logic [7:0] mem [256];
    logic qmode = 0, need_exit = 0, prev_strobe = 0;
    logic [7:0] prev_addr = '0;
    int addr_age = 0, hi_cnt = 0, gap = 1000, nreads = 0, cur_w = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfi_geom_probe i_cfi_geom_probe (
        .clk(clk), .rst_n(rst_n), .start(start), .wait_cycles(wait_cycles),
        .done(done), .geom_valid(geom_valid), .query_fail(query_fail),
        .cmdset_id(cmdset_id), .dev_size(dev_size), .wbuf_size(wbuf_size),
        .region_count(region_count), .rgn_blk_size(rgn_blk_size),
        .rgn_blk_count(rgn_blk_count), .rgn_start(rgn_start), .rgn_end(rgn_end),
        .flash_addr(flash_addr), .flash_wdata(flash_wdata), .flash_rdata(flash_rdata),
        .flash_wr(flash_wr), .flash_rd(flash_rd)
    );

    assign flash_rdata = flash_rd ? (qmode ? mem[flash_addr] : 8'hEE) : 8'h00;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // flash mode model
    always @(posedge clk) if (flash_wr && flash_addr == 8'h55) begin
        if (flash_wdata == 8'h98) qmode <= 1'b1;
        else if (flash_wdata == 8'hFF) qmode <= 1'b0;
    end

    // bus protocol monitor
    always @(negedge clk) begin
        logic strobe;
        strobe = flash_rd || flash_wr;
        if (!rst_n) begin
            prev_strobe = 0; addr_age = 0; gap = 1000; hi_cnt = 0;
        end else begin
            if (flash_addr != prev_addr) addr_age = 0; else addr_age++;
            if (strobe && !prev_strobe) begin
                chk(addr_age >= cur_w + 1, "R2 setup", 64'(addr_age), 64'(cur_w + 1));
                chk(gap >= 2 * (cur_w + 1), "R2 gap", 64'(gap), 64'(2 * (cur_w + 1)));
                hi_cnt = 1;
                if (flash_rd) begin
                    nreads++;
                    chk(qmode, "R1 read in query mode", 64'(qmode), 64'd1);
                    chk(!need_exit, "R1 exit before read", 64'(need_exit), 64'd0);
                    need_exit = 1;
                end else if (flash_wdata == 8'hFF) need_exit = 0;
            end else if (strobe) hi_cnt++;
            if (!strobe && prev_strobe) begin
                chk(hi_cnt == cur_w + 1, "R2 strobe width", 64'(hi_cnt), 64'(cur_w + 1));
                gap = 1;
            end else if (!strobe) gap++;
        end
        prev_strobe = strobe;
        prev_addr = flash_addr;
    end

    function automatic logic [31:0] mkdesc(input int seed, input int r);
        if (seed == 0) return 32'hFFFF_FFFF;
        if (seed == 1) return (r == 1) ? 32'h0 : {16'(r + 1), 16'(r * 3)};
        return {16'(seed * 97 + r * 4093), 16'(seed * 31 + r * 7)};
    endfunction

    task automatic run_case(input logic [7:0] s0, input logic [7:0] s1, input logic [7:0] s2,
                            input logic [7:0] id, input logic [7:0] sx, input logic [7:0] wx,
                            input logic [7:0] nr, input int seed, input int w, input bit poke);
        int cyc, n, exp_reads, failpos;
        logic [63:0] acc, bs, bc, en, exp_sz, exp_wb;
        logic [31:0] d;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        mem[8'h10] = s0; mem[8'h11] = s1; mem[8'h12] = s2;
        mem[8'h13] = id; mem[8'h27] = sx; mem[8'h2A] = wx; mem[8'h2C] = nr;
        for (int r = 0; r < 5; r++) begin
            d = mkdesc(seed, r);
            for (int b = 0; b < 4; b++) mem[8'h2D + 4 * r + b] = d[8*b +: 8];
        end
        wait_cycles = 4'(w); cur_w = w; nreads = 0;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1; @(negedge clk) start = 0;
        end
        cyc = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        chk(done, "R9 done seen", 64'(done), 64'd1);
        failpos = (s0 != 8'h51) ? 0 : (s1 != 8'h52) ? 1 : (s2 != 8'h59) ? 2 : -1;
        n = (nr > 8'd4) ? 4 : int'(nr);
        exp_reads = (failpos >= 0) ? failpos + 1 : 7 + 4 * n;
        chk(nreads == exp_reads, "R6/R10 read count", 64'(nreads), 64'(exp_reads));
        chk(geom_valid == (failpos < 0), "R3 valid", 64'(geom_valid), 64'(failpos < 0));
        chk(query_fail == (failpos >= 0), "R3 fail", 64'(query_fail), 64'(failpos >= 0));
        exp_sz = (failpos < 0 && sx < 32) ? (64'd1 << sx) : 64'd0;
        exp_wb = (failpos < 0 && wx < 32) ? (64'd1 << wx) : 64'd0;
        chk(cmdset_id == ((failpos < 0) ? id : 8'h0), "R4 id", 64'(cmdset_id), 64'((failpos < 0) ? id : 8'h0));
        chk(64'(dev_size) == exp_sz, "R5 dev_size", 64'(dev_size), exp_sz);
        chk(64'(wbuf_size) == exp_wb, "R5 wbuf_size", 64'(wbuf_size), exp_wb);
        if (failpos >= 0) n = 0;
        chk(region_count == 3'(n), "R6 region_count", 64'(region_count), 64'(n));
        acc = 0;
        for (int r = 0; r < NREG; r++) begin
            if (r < n) begin
                d = mkdesc(seed, r);
                bs = 64'(d[31:16]) * 256; bc = 64'(d[15:0]) + 1;
                en = (acc + bs * bc) & ((64'd1 << RA_W) - 1);
            end else begin
                bs = 0; bc = 0; en = 0;
            end
            chk(64'(rgn_blk_size[r*24 +: 24]) == bs, "R7 block size", 64'(rgn_blk_size[r*24 +: 24]), bs);
            chk(64'(rgn_blk_count[r*17 +: 17]) == bc, "R7 block count", 64'(rgn_blk_count[r*17 +: 17]), bc);
            chk(64'(rgn_start[r*RA_W +: RA_W]) == ((r < n) ? acc : 64'd0), "R8 start",
                64'(rgn_start[r*RA_W +: RA_W]), (r < n) ? acc : 64'd0);
            chk(64'(rgn_end[r*RA_W +: RA_W]) == en, "R8 end", 64'(rgn_end[r*RA_W +: RA_W]), en);
            if (r < n) acc = en;
        end
        repeat (3) @(negedge clk);
        chk(!done, "R9 done one cycle", 64'(done), 64'd0);
        chk(geom_valid == (failpos < 0) && query_fail == (failpos >= 0), "R9 flags hold",
            64'({geom_valid, query_fail}), 64'({failpos < 0, failpos >= 0}));
        chk(!qmode, "R1 left in array mode", 64'(qmode), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !geom_valid && !query_fail && region_count == 0 && !flash_rd && !flash_wr,
            "R9 reset state", 64'({done, geom_valid, query_fail, flash_rd, flash_wr}), 64'd0);
        rst_n = 1;
        @(negedge clk);
        // region-count sweep, including clamp
        for (int nr = 0; nr <= 6; nr++)
            run_case(8'h51, 8'h52, 8'h59, 8'h01, 8'(16 + nr), 8'(nr + 2), 8'(nr), 2 + nr, 0, 0);
        // wait-cycle sweep
        for (int w = 1; w <= 3; w++)
            run_case(8'h51, 8'h52, 8'h59, 8'h03, 8'd20, 8'd6, 8'd3, 5, w, 0);
        // extreme descriptors and zero block size
        run_case(8'h51, 8'h52, 8'h59, 8'h02, 8'd31, 8'd0, 8'd4, 0, 0, 0);
        run_case(8'h51, 8'h52, 8'h59, 8'h02, 8'd32, 8'd40, 8'd3, 1, 1, 0);
        // signature mismatch at each position
        run_case(8'h50, 8'h52, 8'h59, 8'h02, 8'd20, 8'd5, 8'd2, 3, 0, 0);
        run_case(8'h51, 8'h00, 8'h59, 8'h02, 8'd20, 8'd5, 8'd2, 3, 1, 0);
        run_case(8'h51, 8'h52, 8'h5A, 8'h02, 8'd20, 8'd5, 8'd2, 3, 0, 0);
        // start during a run is ignored (R10), and a new run clears a failed one (R9)
        run_case(8'h51, 8'h52, 8'h59, 8'h07, 8'd22, 8'd8, 8'd2, 9, 0, 1);
        run_case(8'h51, 8'h52, 8'h59, 8'h07, 8'd22, 8'd8, 8'd4, 11, 2, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule